// File: doc/BRIEF.md
# Cascaded Priority Interrupt Controller

This block gathers sixteen device interrupt lines and raises a single interrupt to the processor. It is built from two eight-line controller units. The primary unit owns lines 0 to 7. The secondary unit owns lines 8 to 15, and its request output feeds primary line 2. Because of that wiring, the secondary's lines sit inside the primary's priority order at the position of line 2. When the processor acknowledges, the block returns an 8-bit vector number for the winning line. The vector is the owning unit's programmable base with the line's index in the low three bits.

Each unit holds its own pending, mask, in-service and base registers, and takes a non-specific end-of-interrupt command. A line that is in service holds back every request of equal or lower priority until software retires it. A request that comes from the secondary is retired with one end-of-interrupt to each unit. A device wired to line 2 has no place in the primary, because that input carries the cascade, so its request is merged into secondary line 1 (line 9).

Top module: `cascaded_irq_ctrl`

## Requirements
- R1: After reset `int_o` and `vec_valid_o` are low, no line is masked, the primary base is 08h and the secondary base is 70h.
- R2: A low-to-high transition on a request line makes that line pending, and `int_o` can go high on the clock edge at which the transition is sampled. A line that is held high afterwards does not raise a new request once the first has been acknowledged.
- R3: Line n in 0..7 (except 2) yields vector primary_base+n. Line n in 8..15 yields secondary_base+(n-8). Line 2 is delivered as line 9.
- R4: When several lines are pending together, the winner follows the order 0, 1, 8, 9, 10, 11, 12, 13, 14, 15, 3, 4, 5, 6, 7.
- R5: An `ack_i` cycle while `int_o` is high presents the vector on `vec_o` with `vec_valid_o` high for the following cycle. The acknowledged line is marked in service and its pending state is cleared. An `ack_i` while `int_o` is low yields no vector.
- R6: While a line is in service, requests of equal or lower priority do not raise `int_o`, and higher-priority requests do.
- R7: An end-of-interrupt command (address bits 1:0 = 0) clears the highest-priority in-service bit of the unit selected by address bit 2 (0 = primary, 1 = secondary). It has no effect on a unit that has nothing in service.
- R8: After a secondary request has been acknowledged, an end-of-interrupt to the secondary alone leaves lines 3..7 and all other secondary lines blocked. The primary end-of-interrupt releases them.
- R9: Writing address bits 1:0 = 1 loads the selected unit's mask, where bit k set masks that unit's line k. A masked line never raises `int_o`, but its edge is still recorded and is delivered once the line is unmasked. Masking primary line 2 hides all secondary lines.
- R10: Writing address bits 1:0 = 2 loads the selected unit's base from `wr_data_i[7:3]`. The low three bits are discarded.
- R11: A request that stays pending while another line is in service raises `int_o` as soon as the blocking in-service bit is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_i | input | 16 | Device request lines, edge-sensitive |
| wr_en_i | input | 1 | Command write strobe |
| wr_addr_i | input | 3 | Bit 2 selects the unit; bits 1:0 select the operation: 0 end-of-interrupt, 1 mask, 2 base, 3 none |
| wr_data_i | input | 8 | Command write data |
| ack_i | input | 1 | Processor interrupt acknowledge |
| int_o | output | 1 | Interrupt request to the processor |
| vec_valid_o | output | 1 | Vector valid, one cycle after an accepted acknowledge |
| vec_o | output | 8 | Vector number |

## Verification
The bench builds the block with its default parameters: eight lines per unit, the cascade on primary line 2, and line 2 merged into secondary line 1. That small configuration lets the bench drive every single line and every ordered pair of distinct lines. Each pair checks both vectors, the order in which they are delivered and the two-step retirement of secondary lines. Separate directed sequences cover masking, preemption, base reprogramming with the low bits discarded, and spurious acknowledge and end-of-interrupt commands.

// File: rtl/cpic_pkg.sv
// Shared definitions for the cascaded interrupt controller.
// Assumes an 8-bit vector number.
package cpic_pkg;
    localparam int VEC_W = 8;

    typedef enum logic [1:0] {
        OP_EOI  = 2'd0,
        OP_MASK = 2'd1,
        OP_BASE = 2'd2,
        OP_NONE = 2'd3
    } cpic_op_e;
endpackage

// File: rtl/cpic_prio.sv
// Fixed-priority encoder: the lowest set index wins.
// Assumes N >= 2. any_o is low and idx_o is 0 when no bit is set.
module cpic_prio #(
    parameter int N  = 8,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]  bits_i,
    output logic          any_o,
    output logic [IW-1:0] idx_o
);
    // scan from the top index down so that the lowest set index is kept
    always_comb begin
        any_o = 1'b0;
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (bits_i[i]) begin
                any_o = 1'b1;
                idx_o = IW'(i);
            end
        end
    end
endmodule

// File: rtl/cpic_unit.sv
// One N-line interrupt controller unit: edge capture, mask, in-service
// tracking, fixed priority and a programmable vector base. The cascade
// input is a level that is ORed into line CAS_LINE. ack_i must only be
// asserted while int_o is high.
module cpic_unit #(
    parameter int            N        = 8,
    parameter int            CAS_LINE = 2,
    parameter logic [7:0]    RST_BASE = 8'h08,
    localparam int           IW       = $clog2(N),
    localparam int           BW       = cpic_pkg::VEC_W - IW
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [N-1:0]              req_i,
    input  logic                      cas_i,
    input  logic                      ack_i,
    input  logic                      eoi_i,
    input  logic                      mask_we_i,
    input  logic                      base_we_i,
    input  logic [cpic_pkg::VEC_W-1:0] wdata_i,
    output logic                      int_o,
    output logic [IW-1:0]             idx_o,
    output logic [cpic_pkg::VEC_W-1:0] vec_o
);
    localparam logic [N-1:0] CAS_BIT = N'(1) << CAS_LINE;

    logic [N-1:0]  prev_q, pend_q, mask_q, insvc_q;
    logic [BW-1:0] base_q;
    logic [N-1:0]  rise, pend_eff, cand, ack_clr, eoi_clr;
    logic          c_any, s_any;
    logic [IW-1:0] c_idx, s_idx;

    // per-line rising-edge detection
    for (genvar g = 0; g < N; g++) begin : g_edge
        assign rise[g] = req_i[g] & ~prev_q[g];
    end

    assign pend_eff = pend_q | (cas_i ? CAS_BIT : '0);
    assign cand     = pend_eff & ~mask_q;

    cpic_prio #(.N(N)) u_req_prio (.bits_i(cand),    .any_o(c_any), .idx_o(c_idx));
    cpic_prio #(.N(N)) u_svc_prio (.bits_i(insvc_q), .any_o(s_any), .idx_o(s_idx));

    // request goes out only if it outranks the highest line in service
    assign int_o   = c_any && (!s_any || (c_idx < s_idx));
    assign idx_o   = c_idx;
    assign vec_o   = {base_q, c_idx};
    assign ack_clr = ack_i ? (N'(1) << c_idx) : '0;
    assign eoi_clr = (eoi_i && s_any) ? (N'(1) << s_idx) : '0;

    // state update: edges, acknowledge, end-of-interrupt, register writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q  <= '0;
            pend_q  <= '0;
            mask_q  <= '0;
            insvc_q <= '0;
            base_q  <= RST_BASE[cpic_pkg::VEC_W-1:IW];
        end else begin
            prev_q  <= req_i;
            pend_q  <= (pend_q & ~ack_clr) | rise;
            insvc_q <= (insvc_q | ack_clr) & ~eoi_clr;
            if (mask_we_i) mask_q <= wdata_i[N-1:0];
            if (base_we_i) base_q <= wdata_i[cpic_pkg::VEC_W-1:IW];
        end
    end
endmodule

// File: rtl/cascaded_irq_ctrl.sv
// Two cascaded interrupt controller units. The secondary's request feeds
// primary line CAS_LINE, and device line CAS_LINE is redirected to
// secondary line SHARE_LINE. Commands are decoded from wr_addr_i: bit 2
// selects the unit and bits 1:0 the operation.
module cascaded_irq_ctrl #(
    parameter int         N          = 8,
    parameter int         CAS_LINE   = 2,
    parameter int         SHARE_LINE = 1,
    parameter logic [7:0] PRI_BASE   = 8'h08,
    parameter logic [7:0] SEC_BASE   = 8'h70,
    localparam int        NL         = 2 * N,
    localparam int        IW         = $clog2(N)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [15:0] irq_i,
    input  logic        wr_en_i,
    input  logic [2:0]  wr_addr_i,
    input  logic [7:0]  wr_data_i,
    input  logic        ack_i,
    output logic        int_o,
    output logic        vec_valid_o,
    output logic [7:0]  vec_o
);
    import cpic_pkg::*;

    localparam logic [N-1:0] CAS_BIT   = N'(1) << CAS_LINE;
    localparam logic [N-1:0] SHARE_BIT = N'(1) << SHARE_LINE;

    logic [N-1:0]  pri_req, sec_req;
    logic          pri_int, sec_int, take, from_sec;
    logic [IW-1:0] pri_idx, sec_idx;
    logic [7:0]    pri_vec, sec_vec, vec_q;
    logic          valid_q;
    logic [1:0]    we_eoi, we_mask, we_base;
    cpic_op_e      op;

    assign pri_req = irq_i[N-1:0] & ~CAS_BIT;
    assign sec_req = irq_i[NL-1:N] | (irq_i[CAS_LINE] ? SHARE_BIT : '0);

    // command decode, one strobe per unit and operation
    always_comb begin
        op      = cpic_op_e'(wr_addr_i[1:0]);
        we_eoi  = '0;
        we_mask = '0;
        we_base = '0;
        if (wr_en_i) begin
            we_eoi [wr_addr_i[2]] = (op == OP_EOI);
            we_mask[wr_addr_i[2]] = (op == OP_MASK);
            we_base[wr_addr_i[2]] = (op == OP_BASE);
        end
    end

    assign take     = ack_i && pri_int;
    assign from_sec = (pri_idx == IW'(CAS_LINE));

    cpic_unit #(.N(N), .CAS_LINE(CAS_LINE), .RST_BASE(PRI_BASE)) u_pri (
        .clk(clk), .rst_n(rst_n), .req_i(pri_req), .cas_i(sec_int),
        .ack_i(take), .eoi_i(we_eoi[0]), .mask_we_i(we_mask[0]),
        .base_we_i(we_base[0]), .wdata_i(wr_data_i),
        .int_o(pri_int), .idx_o(pri_idx), .vec_o(pri_vec)
    );

    cpic_unit #(.N(N), .CAS_LINE(0), .RST_BASE(SEC_BASE)) u_sec (
        .clk(clk), .rst_n(rst_n), .req_i(sec_req), .cas_i(1'b0),
        .ack_i(take && from_sec), .eoi_i(we_eoi[1]), .mask_we_i(we_mask[1]),
        .base_we_i(we_base[1]), .wdata_i(wr_data_i),
        .int_o(sec_int), .idx_o(sec_idx), .vec_o(sec_vec)
    );

    // latch the vector of the winning unit on an accepted acknowledge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_q   <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= take;
            if (take) vec_q <= from_sec ? sec_vec : pri_vec;
        end
    end

    assign int_o       = pri_int;
    assign vec_valid_o = valid_q;
    assign vec_o       = vec_q;

    logic unused_ok;
    assign unused_ok = ^sec_idx;
endmodule

// File: rtl/cpic_checker.sv
// Port-level checks for cascaded_irq_ctrl. It keeps a shadow of the
// primary mask and of both bases, built from the command writes.
module cpic_checker #(
    parameter logic [7:0] PRI_BASE = 8'h08,
    parameter logic [7:0] SEC_BASE = 8'h70
) (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en_i,
    input logic [2:0] wr_addr_i,
    input logic [7:0] wr_data_i,
    input logic       ack_i,
    input logic       int_o,
    input logic       vec_valid_o,
    input logic [7:0] vec_o
);
    logic [7:0] pmask_s;
    logic [4:0] pbase_s, sbase_s;

    // shadow registers updated from command writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pmask_s <= '0;
            pbase_s <= PRI_BASE[7:3];
            sbase_s <= SEC_BASE[7:3];
        end else if (wr_en_i) begin
            if (wr_addr_i == 3'd1) pmask_s <= wr_data_i;
            if (wr_addr_i == 3'd2) pbase_s <= wr_data_i[7:3];
            if (wr_addr_i == 3'd6) sbase_s <= wr_data_i[7:3];
        end
    end

    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (!int_o && !vec_valid_o));

    assert_vec_after_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid_o |-> $past(ack_i && int_o));

    assert_no_vec_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && !int_o) |=> !vec_valid_o);

    assert_full_mask_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pmask_s == 8'hFF) |-> !int_o);

    assert_vec_base_R10: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid_o |-> (vec_o[7:3] == $past(pbase_s) || vec_o[7:3] == $past(sbase_s)));
endmodule

bind cascaded_irq_ctrl cpic_checker u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .ack_i(ack_i), .int_o(int_o),
    .vec_valid_o(vec_valid_o), .vec_o(vec_o)
);

// File: tb/tb_cascaded_irq_ctrl.sv
module tb_cascaded_irq_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] irq = '0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        ack = 1'b0;
    logic        int_o, vec_valid, vout_valid;
    logic [7:0]  vec, vout;
    int          total = 0, bad = 0;
    int          pb = 8'h08, sb = 8'h70;
    bit          finished = 1'b0;

    always #2 clk = ~clk;

    cascaded_irq_ctrl dut (
        .clk(clk), .rst_n(rst_n), .irq_i(irq), .wr_en_i(wr_en),
        .wr_addr_i(wr_addr), .wr_data_i(wr_data), .ack_i(ack),
        .int_o(int_o), .vec_valid_o(vec_valid), .vec_o(vec)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic bit is_sec(input int n);
        return (n >= 8) || (n == 2);
    endfunction

    function automatic int exp_vec(input int n);
        if (n == 2) return sb + 1;
        if (n < 8)  return pb + n;
        return sb + n - 8;
    endfunction

    function automatic int rank(input int n);
        if (n < 2)  return n;
        if (n >= 8) return n - 6;
        if (n == 2) return 3;
        return n + 7;
    endfunction

    task automatic pulse(input int a, input int b);
        @(negedge clk); irq[a] = 1'b1; irq[b] = 1'b1;
        @(negedge clk); irq[a] = 1'b0; irq[b] = 1'b0;
    endtask

    task automatic wr(input int addr, input int data);
        @(negedge clk); wr_en = 1'b1; wr_addr = 3'(addr); wr_data = 8'(data);
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic do_ack();
        @(negedge clk); ack = 1'b1;
        @(posedge clk); #1 vout = vec; vout_valid = vec_valid;
        @(negedge clk); ack = 1'b0;
    endtask

    task automatic retire(input int n);
        if (is_sec(n)) wr(4, 0);
        wr(0, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 int after reset", int_o, 0);
        chk("R1 valid after reset", vec_valid, 0);

        // R5: acknowledge with nothing pending
        do_ack();
        chk("R5 idle ack", vout_valid, 0);

        // single-line sweep at reset bases (R1, R2, R3)
        for (int n = 0; n < 16; n++) begin
            pulse(n, n);
            chk("R2 int on edge", int_o, 1);
            do_ack();
            chk("R5 valid", vout_valid, 1);
            chk("R3 vector", vout, exp_vec(n));
            @(negedge clk);
            chk("R5 valid one cycle", vec_valid, 0);
            retire(n);
            chk("R3 idle after retire", int_o, 0);
        end

        // every ordered pair of lines (R4, R8, R11)
        for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 16; b++) begin
                int hi, lo;
                if (a == b || a == 2 || b == 2) continue;
                hi = (rank(a) < rank(b)) ? a : b;
                lo = (hi == a) ? b : a;
                pulse(a, b);
                do_ack();
                chk("R4 winner", vout, exp_vec(hi));
                if (is_sec(hi)) begin
                    wr(4, 0);
                    chk("R8 blocked after secondary eoi", int_o, 0);
                end
                wr(0, 0);
                chk("R11 queued raised", int_o, 1);
                do_ack();
                chk("R4 second", vout, exp_vec(lo));
                retire(lo);
            end
        end

        // R6 / R7 nesting and preemption
        pulse(5, 5); do_ack();
        pulse(6, 6);
        chk("R6 lower blocked", int_o, 0);
        pulse(5, 5);
        chk("R6 equal blocked", int_o, 0);
        wr(4, 0);
        chk("R7 eoi on empty secondary ignored", int_o, 0);
        pulse(3, 3);
        chk("R6 higher preempts", int_o, 1);
        do_ack();
        chk("R6 preempt vector", vout, pb + 3);
        wr(0, 0);
        chk("R7 clears only highest", int_o, 0);
        wr(0, 0);
        chk("R11 pending after eoi", int_o, 1);
        do_ack();
        chk("R7 next vector", vout, pb + 5);
        wr(0, 0);
        do_ack();
        chk("R7 last vector", vout, pb + 6);
        wr(0, 0);
        chk("R7 all retired", int_o, 0);

        // R2 held level does not retrigger
        @(negedge clk); irq[4] = 1'b1;
        @(negedge clk);
        do_ack();
        chk("R2 held vector", vout, pb + 4);
        wr(0, 0);
        @(negedge clk);
        chk("R2 held no retrigger", int_o, 0);
        irq[4] = 1'b0;
        pulse(4, 4);
        chk("R2 new edge", int_o, 1);
        do_ack(); wr(0, 0);

        // R9 masking
        wr(1, 8'h10);
        pulse(4, 4);
        chk("R9 masked primary", int_o, 0);
        wr(1, 0);
        chk("R9 unmasked delivers", int_o, 1);
        do_ack();
        chk("R9 vector", vout, pb + 4);
        wr(0, 0);
        wr(5, 8'h10);
        pulse(12, 12);
        chk("R9 masked secondary", int_o, 0);
        wr(5, 0);
        chk("R9 secondary unmask", int_o, 1);
        do_ack(); retire(12);
        wr(1, 8'h04);
        pulse(9, 9);
        chk("R9 cascade mask hides secondary", int_o, 0);
        wr(1, 0);
        do_ack();
        chk("R9 cascade vector", vout, sb + 1);
        retire(9);

        // R10 base writes keep bits 7:3 only
        wr(2, 8'h27); pb = 8'h20;
        wr(6, 8'h9F); sb = 8'h98;
        for (int n = 0; n < 16; n++) begin
            pulse(n, n);
            do_ack();
            chk("R10 vector", vout, exp_vec(n));
            retire(n);
        end
        wr(3, 8'hFF);
        pulse(7, 7);
        do_ack();
        chk("R10 unused address ignored", vout, pb + 7);
        wr(0, 0);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule